// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the scan timing for a flat-panel or television output. Two counters walk every frame: one over the pixels of a line and one over the lines of a frame. From their values the block decodes a horizontal sync, a vertical sync and a data-enable that marks the visible window. It also exports the current pixel and line position, a field indicator for interlaced scan, a start strobe on a programmable line, and a sticky interrupt flag raised when a chosen line begins. Software programs all geometry through a small word-addressed write port with a combinational read-back. Pixels advance on a pixel-clock enable that an internal divider can slow down further.

The horizontal back porch is counted from the first sync pixel, so it includes the sync width. The vertical total is held in half-line units. Geometry and scan mode are shadowed: a write becomes visible at the next frame boundary, so no frame mixes old and new settings. Polarity, the pad tri-state mask, the divider and the interrupt line act at once.

Register map (word index on `addr`; "hi" means bits 31:16, "lo" bits 15:0, and only the low counter-width bits of each half are kept): 0 global run (bit 0); 1 channel control (bit 31 channel run, bit 24 interlace, bits 12:8 start line, bits 3:0 divider); 2 active size (hi width-1, lo height-1); 3 horizontal (hi pixels per line-1, lo back porch-1); 4 vertical (hi total in half lines, lo back porch-1); 5 sync (hi hsync width-1, lo vsync width-1); 6 polarity (bit 0 hsync, bit 1 vsync, bit 2 data enable); 7 tri-state mask (bit 0 hsync pad, bit 1 vsync pad, bit 2 data-enable pad); 8 interrupt (lo line number; read bit 31 is the flag; a write with bit 31 set clears it).

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads 0 except the tri-state mask, which reads 7; both run bits are clear, all pads are disabled, the position outputs are 0, hsync, vsync, data enable and start strobe are low and the interrupt flag is clear.
- R2: Pixels advance only while global run (reg 0 bit 0) and channel run (reg 1 bit 31) are both 1; with either clear, both positions return to 0 on the next clock and hsync, vsync and data enable sit at their inactive level (equal to their polarity bit).
- R3: A line lasts (reg 3 hi)+1 pixels, and hsync is active for the first (reg 5 hi)+1 pixels of each line.
- R4: Data enable is active on pixels hbp to hbp+width-1 of lines vbp to vbp+height-1, where hbp=(reg 3 lo)+1 pixels counted from the first hsync pixel, vbp=(reg 4 lo)+1, width=(reg 2 hi)+1 and height=(reg 2 lo)+1.
- R5: In progressive scan a frame lasts (reg 4 hi)/2 lines, rounded down, and vsync is active on its first (reg 5 lo)+1 lines.
- R6: With interlace (reg 1 bit 24) set, `field_o` toggles at each frame boundary; field 0 lasts (reg 4 hi)/2 lines rounded down and field 1 lasts one line more when reg 4 hi is odd.
- R7: Polarity bit 0, 1 and 2 of reg 6 invert hsync, vsync and data enable respectively, each independently and at once.
- R8: `pad_oe_o[i]` is the inverse of tri-state mask bit i of reg 7, with pad order hsync, vsync, data enable from bit 0.
- R9: `start_o` is high for exactly pixel 0 of the line whose number equals reg 1 bits 12:8, while running.
- R10: The interrupt flag sets when pixel 0 of the line numbered in reg 8 lo is reached; it stays set until a write to reg 8 with bit 31 set, and a set and a clear in the same cycle leave it set.
- R11: Writes to regs 2 to 5 and to the interlace and start-line fields take effect at the next frame start; the running frame keeps its old geometry, while read-back returns the new value at once.
- R12: With divider value d (reg 1 bits 3:0) a pixel advances once every d+1 clocks on which `pix_ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read-back of the register at `addr` |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pad_oe_o | output | 3 | Pad output enables (hsync, vsync, data enable from bit 0) |
| h_pos_o | output | 12 | Current pixel within the line |
| v_pos_o | output | 12 | Current line within the frame or field |
| field_o | output | 1 | Current field in interlaced scan |
| start_o | output | 1 | Start-line strobe |
| irq_o | output | 1 | Sticky line-match interrupt flag |

## Verification
On every cycle the assertions check that the counters sit at zero whenever the block is not running, that neither position passes the last pixel or last line of the shadowed geometry, that a pixel only moves on a divided enable, and that the interrupt flag rises only from a line match and holds until cleared. Whether the sync and data-enable windows land on the right pixels and lines, the frame and field lengths under interlace, the polarity and pad behaviour, and the deferral of geometry writes to the frame boundary can only be shown by the bench's scenarios, which measure whole lines and frames against the programmed values.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int DIV_W  = 4;
    localparam int SD_W   = 5;
    localparam int NPIN   = 3;

    // field positions inside a register word
    localparam int HI_LSB     = 16;
    localparam int LO_LSB     = 0;
    localparam int CH_RUN_BIT = 31;
    localparam int CH_IL_BIT  = 24;
    localparam int CH_SD_LSB  = 8;
    localparam int CH_DIV_LSB = 0;
    localparam int IRQ_FLAG_BIT = 31;

    // pad order
    localparam int PIN_HS = 0;
    localparam int PIN_VS = 1;
    localparam int PIN_DE = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_GLOBAL = 4'd0,
        REG_CHAN   = 4'd1,
        REG_SIZE   = 4'd2,
        REG_HORZ   = 4'd3,
        REG_VERT   = 4'd4,
        REG_SYNC   = 4'd5,
        REG_POL    = 4'd6,
        REG_TRI    = 4'd7,
        REG_IRQ    = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] width_m1;
        logic [CNT_W-1:0] height_m1;
        logic [CNT_W-1:0] htot_m1;
        logic [CNT_W-1:0] hbp_m1;
        logic [CNT_W-1:0] vhalf;
        logic [CNT_W-1:0] vbp_m1;
        logic [CNT_W-1:0] hspw_m1;
        logic [CNT_W-1:0] vspw_m1;
        logic             ilace;
        logic [SD_W-1:0]  sline;
    } timing_t;

    typedef struct packed {
        logic de_inv;
        logic vs_inv;
        logic hs_inv;
    } pol_t;

    function automatic logic [DATA_W-1:0] pack_pair(input logic [CNT_W-1:0] hi,
                                                   input logic [CNT_W-1:0] lo);
        logic [DATA_W-1:0] w;
        w = '0;
        w[HI_LSB +: CNT_W] = hi;
        w[LO_LSB +: CNT_W] = lo;
        return w;
    endfunction

    // position p lies in the window of n+1 entries starting at s_m1+1
    function automatic logic in_window(input logic [CNT_W-1:0] p,
                                       input logic [CNT_W-1:0] s_m1,
                                       input logic [CNT_W-1:0] n_m1);
        logic [CNT_W+1:0] px, first, last;
        px    = {2'b00, p};
        first = {2'b00, s_m1} + 1'b1;
        last  = {2'b00, s_m1} + {2'b00, n_m1} + 1'b1;
        return (px >= first) && (px <= last);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import raster_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_set,
    output logic [DATA_W-1:0] rdata,
    output timing_t           live,
    output logic              run,
    output logic [DIV_W-1:0]  div,
    output pol_t              pol,
    output logic [NPIN-1:0]   tri_mask,
    output logic [CNT_W-1:0]  irq_line,
    output logic              irq_flag,
    output logic              irq_clr
);

    logic glob_en;
    logic chan_en;
    logic unused_wbits;

    assign unused_wbits = ^wdata;
    assign run     = glob_en && chan_en;
    assign irq_clr = wr_en && (addr == REG_IRQ) && wdata[IRQ_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en  <= 1'b0;
            chan_en  <= 1'b0;
            div      <= '0;
            live     <= '0;
            pol      <= '0;
            tri_mask <= '1;
            irq_line <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_GLOBAL: glob_en <= wdata[0];
                REG_CHAN: begin
                    chan_en    <= wdata[CH_RUN_BIT];
                    live.ilace <= wdata[CH_IL_BIT];
                    live.sline <= wdata[CH_SD_LSB +: SD_W];
                    div        <= wdata[CH_DIV_LSB +: DIV_W];
                end
                REG_SIZE: begin
                    live.width_m1  <= wdata[HI_LSB +: CNT_W];
                    live.height_m1 <= wdata[LO_LSB +: CNT_W];
                end
                REG_HORZ: begin
                    live.htot_m1 <= wdata[HI_LSB +: CNT_W];
                    live.hbp_m1  <= wdata[LO_LSB +: CNT_W];
                end
                REG_VERT: begin
                    live.vhalf  <= wdata[HI_LSB +: CNT_W];
                    live.vbp_m1 <= wdata[LO_LSB +: CNT_W];
                end
                REG_SYNC: begin
                    live.hspw_m1 <= wdata[HI_LSB +: CNT_W];
                    live.vspw_m1 <= wdata[LO_LSB +: CNT_W];
                end
                REG_POL: pol      <= pol_t'(wdata[NPIN-1:0]);
                REG_TRI: tri_mask <= wdata[NPIN-1:0];
                REG_IRQ: irq_line <= wdata[LO_LSB +: CNT_W];
                default: ;
            endcase
        end
    end

    // sticky flag, a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            irq_flag <= 1'b0;
        else if (irq_set)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_GLOBAL: rdata[0] = glob_en;
            REG_CHAN: begin
                rdata[CH_RUN_BIT]             = chan_en;
                rdata[CH_IL_BIT]              = live.ilace;
                rdata[CH_SD_LSB +: SD_W]      = live.sline;
                rdata[CH_DIV_LSB +: DIV_W]    = div;
            end
            REG_SIZE: rdata = pack_pair(live.width_m1, live.height_m1);
            REG_HORZ: rdata = pack_pair(live.htot_m1, live.hbp_m1);
            REG_VERT: rdata = pack_pair(live.vhalf, live.vbp_m1);
            REG_SYNC: rdata = pack_pair(live.hspw_m1, live.vspw_m1);
            REG_POL:  rdata[NPIN-1:0] = pol;
            REG_TRI:  rdata[NPIN-1:0] = tri_mask;
            REG_IRQ: begin
                rdata[LO_LSB +: CNT_W] = irq_line;
                rdata[IRQ_FLAG_BIT]    = irq_flag;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter
    import raster_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pix_ce,
    input  logic [DIV_W-1:0] div,
    input  timing_t          live,
    output timing_t          shadow,
    output logic [CNT_W-1:0] h_pos,
    output logic [CNT_W-1:0] v_pos,
    output logic [CNT_W-1:0] v_last,
    output logic             field,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] lines;
    logic             line_end;
    logic             frame_end;

    // enable divider: one pixel per div+1 enabled clocks
    assign tick = run && pix_ce && (div_cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_cnt <= '0;
        else if (pix_ce)
            div_cnt <= (div_cnt >= div) ? '0 : div_cnt + 1'b1;
    end

    // lines in the current field; an odd half-line total lengthens field 1
    always_comb begin
        lines = {1'b0, shadow.vhalf[CNT_W-1:1]};
        if (shadow.ilace && field)
            lines = lines + CNT_W'(shadow.vhalf[0]);
        v_last = lines - CNT_W'(1);
    end

    assign line_end  = tick && (h_pos == shadow.htot_m1);
    assign frame_end = line_end && (v_pos == v_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (!run) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (line_end) begin
            h_pos <= '0;
            v_pos <= frame_end ? '0 : v_pos + 1'b1;
        end else if (tick) begin
            h_pos <= h_pos + 1'b1;
        end
    end

    // geometry follows the registers while idle, else only at a frame boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            field  <= 1'b0;
        end else if (!run) begin
            shadow <= live;
            field  <= 1'b0;
        end else if (frame_end) begin
            shadow <= live;
            field  <= shadow.ilace ? ~field : 1'b0;
        end
    end

endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import raster_timing_pkg::*;
(
    input  logic             run,
    input  logic             tick,
    input  timing_t          sh,
    input  logic [CNT_W-1:0] h_pos,
    input  logic [CNT_W-1:0] v_pos,
    input  pol_t             pol,
    input  logic [NPIN-1:0]  tri_mask,
    input  logic [CNT_W-1:0] irq_line,
    output logic [NPIN-1:0]  pin_val,
    output logic [NPIN-1:0]  pad_oe,
    output logic             start_o,
    output logic             irq_set
);

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] inv;
    logic            unused_sh;

    assign unused_sh = ^{sh.htot_m1, sh.vhalf, sh.ilace};
    assign inv       = pol;

    always_comb begin
        raw         = '0;
        raw[PIN_HS] = run && (h_pos <= sh.hspw_m1);
        raw[PIN_VS] = run && (v_pos <= sh.vspw_m1);
        raw[PIN_DE] = run && in_window(h_pos, sh.hbp_m1, sh.width_m1)
                          && in_window(v_pos, sh.vbp_m1, sh.height_m1);
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        assign pin_val[i] = raw[i] ^ inv[i];
        assign pad_oe[i]  = ~tri_mask[i];
    end

    assign start_o = run && (h_pos == '0) && (v_pos == CNT_W'(sh.sline));
    assign irq_set = tick && (h_pos == '0) && (v_pos == irq_line);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [NPIN-1:0]   pad_oe_o,
    output logic [CNT_W-1:0]  h_pos_o,
    output logic [CNT_W-1:0]  v_pos_o,
    output logic              field_o,
    output logic              start_o,
    output logic              irq_o
);

    timing_t          live;
    timing_t          shadow;
    logic             run;
    logic [DIV_W-1:0] div;
    pol_t             pol;
    logic [NPIN-1:0]  tri_mask;
    logic [CNT_W-1:0] irq_line;
    logic             irq_flag;
    logic             irq_clr;
    logic             irq_set;
    logic [CNT_W-1:0] h_pos;
    logic [CNT_W-1:0] v_pos;
    logic [CNT_W-1:0] v_last;
    logic             field;
    logic             tick;
    logic [NPIN-1:0]  pin_val;

    rtg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .irq_set  (irq_set),
        .rdata    (rdata),
        .live     (live),
        .run      (run),
        .div      (div),
        .pol      (pol),
        .tri_mask (tri_mask),
        .irq_line (irq_line),
        .irq_flag (irq_flag),
        .irq_clr  (irq_clr)
    );

    rtg_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .pix_ce (pix_ce),
        .div    (div),
        .live   (live),
        .shadow (shadow),
        .h_pos  (h_pos),
        .v_pos  (v_pos),
        .v_last (v_last),
        .field  (field),
        .tick   (tick)
    );

    rtg_decode u_dec (
        .run      (run),
        .tick     (tick),
        .sh       (shadow),
        .h_pos    (h_pos),
        .v_pos    (v_pos),
        .pol      (pol),
        .tri_mask (tri_mask),
        .irq_line (irq_line),
        .pin_val  (pin_val),
        .pad_oe   (pad_oe_o),
        .start_o  (start_o),
        .irq_set  (irq_set)
    );

    assign hsync_o = pin_val[PIN_HS];
    assign vsync_o = pin_val[PIN_VS];
    assign de_o    = pin_val[PIN_DE];
    assign h_pos_o = h_pos;
    assign v_pos_o = v_pos;
    assign field_o = field;
    assign irq_o   = irq_flag;

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk
    import raster_timing_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             tick,
    input logic [CNT_W-1:0] h_pos,
    input logic [CNT_W-1:0] v_pos,
    input logic [CNT_W-1:0] htot_m1,
    input logic [CNT_W-1:0] v_last,
    input logic             irq_flag,
    input logic             irq_set,
    input logic             irq_clr
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (h_pos == '0) && (v_pos == '0));

    // R3
    hpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        h_pos <= htot_m1);

    // R5
    vpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        v_pos <= v_last);

    // R12
    pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(h_pos) && $stable(v_pos));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R10
    irq_setwin_chk: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> irq_flag);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(irq_set));

endmodule

bind raster_timing_gen raster_timing_gen_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .h_pos    (h_pos),
    .v_pos    (v_pos),
    .htot_m1  (shadow.htot_m1),
    .v_last   (v_last),
    .irq_flag (irq_flag),
    .irq_set  (irq_set),
    .irq_clr  (irq_clr)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    import raster_timing_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              pix_ce;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              hsync_o, vsync_o, de_o, field_o, start_o, irq_o;
    logic [NPIN-1:0]   pad_oe_o;
    logic [CNT_W-1:0]  h_pos_o, v_pos_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // programmed geometry: 10 px/line, 8 lines, 4x3 active at (3,2)
    localparam logic [31:0] CFG_SIZE = 32'h0003_0002;
    localparam logic [31:0] CFG_HORZ = 32'h0009_0002;
    localparam logic [31:0] CFG_VERT = 32'h0010_0001;
    localparam logic [31:0] CFG_SYNC = 32'h0001_0000;
    localparam logic [31:0] CFG_CHAN = 32'h8000_0300;

    always #5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .pix_ce   (pix_ce),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .de_o     (de_o),
        .pad_oe_o (pad_oe_o),
        .h_pos_o  (h_pos_o),
        .v_pos_o  (v_pos_o),
        .field_o  (field_o),
        .start_o  (start_o),
        .irq_o    (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input reg_addr_e a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_pos(input int h, input int v);
        while (!(h_pos_o == CNT_W'(h) && v_pos_o == CNT_W'(v))) @(negedge clk);
    endtask

    // clocks from one entry into pixel 0 to the next
    task automatic line_len(output int n);
        bit seen;
        while (h_pos_o == '0) @(negedge clk);
        while (h_pos_o != '0) @(negedge clk);
        n = 0;
        seen = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (h_pos_o != '0) seen = 1'b1;
        end while (!(seen && h_pos_o == '0));
    endtask

    task automatic measure_frame(output int len, output int hs, output int vs, output int de);
        wait_pos(0, 0);
        len = 0; hs = 0; vs = 0; de = 0;
        do begin
            hs += int'(hsync_o);
            vs += int'(vsync_o);
            de += int'(de_o);
            len++;
            @(negedge clk);
        end while (!(h_pos_o == '0 && v_pos_o == '0));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(REG_CHAN, d);  check("R1 chan reg", d, 32'h0);
        rd(REG_SIZE, d);  check("R1 size reg", d, 32'h0);
        rd(REG_TRI, d);   check("R1 tri reg", d, 32'h7);
        check("R1 pads", {29'b0, pad_oe_o}, 32'h0);
        check("R1 outputs", {hsync_o, vsync_o, de_o, start_o, irq_o}, 5'b0);
        check("R1 position", {h_pos_o, v_pos_o}, 24'h0);
    endtask

    task automatic t_tristate;
        wr(REG_TRI, 32'h0);
        check("R8 all pads on", {29'b0, pad_oe_o}, 32'h7);
        wr(REG_TRI, 32'h2);
        check("R8 vsync pad off", {29'b0, pad_oe_o}, 32'h5);
        wr(REG_TRI, 32'h0);
    endtask

    task automatic t_enables;
        wr(REG_SIZE, CFG_SIZE);
        wr(REG_HORZ, CFG_HORZ);
        wr(REG_VERT, CFG_VERT);
        wr(REG_SYNC, CFG_SYNC);
        wr(REG_IRQ, 32'h8000_0004);
        wr(REG_CHAN, CFG_CHAN);
        repeat (20) @(negedge clk);
        check("R2 channel only", {h_pos_o, v_pos_o}, 24'h0);
        check("R2 channel only hsync", {31'b0, hsync_o}, 32'h0);
        wr(REG_CHAN, 32'h0000_0300);
        wr(REG_GLOBAL, 32'h1);
        repeat (20) @(negedge clk);
        check("R2 global only", {h_pos_o, v_pos_o}, 24'h0);
        wr(REG_CHAN, CFG_CHAN);
        check("R2 start at origin", {h_pos_o, v_pos_o}, 24'h0);
        repeat (5) @(negedge clk);
        check("R2 both run", {20'b0, h_pos_o}, 32'd5);
    endtask

    task automatic t_geometry;
        int len, hs, vs, de, n;
        measure_frame(len, hs, vs, de);
        check("R5 frame length", len, 80);
        check("R3 hsync pixels", hs, 16);
        check("R5 vsync pixels", vs, 10);
        check("R4 active pixels", de, 12);
        line_len(n);
        check("R3 line length", n, 10);
        wait_pos(2, 2); check("R4 before window", {31'b0, de_o}, 32'h0);
        wait_pos(3, 2); check("R4 first active", {31'b0, de_o}, 32'h1);
        wait_pos(6, 4); check("R4 last active", {31'b0, de_o}, 32'h1);
        wait_pos(7, 4); check("R4 after window", {31'b0, de_o}, 32'h0);
        wait_pos(1, 6); check("R3 hsync second pixel", {31'b0, hsync_o}, 32'h1);
        wait_pos(2, 6); check("R3 hsync ended", {31'b0, hsync_o}, 32'h0);
    endtask

    task automatic t_start;
        wait_pos(0, 2); check("R9 other line", {31'b0, start_o}, 32'h0);
        wait_pos(0, 3); check("R9 start line", {31'b0, start_o}, 32'h1);
        @(negedge clk); check("R9 one pixel", {31'b0, start_o}, 32'h0);
    endtask

    task automatic t_irq;
        wait_pos(0, 5); check("R10 flag set", {31'b0, irq_o}, 32'h1);
        wait_pos(0, 6);
        wr(REG_IRQ, 32'h8000_0004);
        check("R10 cleared", {31'b0, irq_o}, 32'h0);
        wait_pos(0, 4);
        check("R10 not yet set", {31'b0, irq_o}, 32'h0);
        wr(REG_IRQ, 32'h8000_0004);
        check("R10 set wins", {31'b0, irq_o}, 32'h1);
        wait_pos(0, 0);
        check("R10 sticky", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_polarity;
        wr(REG_POL, 32'h7);
        wait_pos(0, 0);
        check("R7 hsync inverted", {31'b0, hsync_o}, 32'h0);
        check("R7 vsync inverted", {31'b0, vsync_o}, 32'h0);
        wait_pos(3, 2); check("R7 de inverted", {31'b0, de_o}, 32'h0);
        wait_pos(5, 5);
        check("R7 idle levels", {29'b0, hsync_o, vsync_o, de_o}, 32'h7);
        wr(REG_POL, 32'h2);
        wait_pos(0, 0);
        check("R7 only vsync inverted", {30'b0, hsync_o, vsync_o}, 32'h2);
        wr(REG_POL, 32'h0);
    endtask

    task automatic t_shadow;
        int n;
        logic [31:0] d;
        wait_pos(0, 3);
        wr(REG_HORZ, 32'h000B_0002);
        rd(REG_HORZ, d);
        check("R11 read back new", d, 32'h000B_0002);
        line_len(n);
        check("R11 old line kept", n, 10);
        wait_pos(0, 0);
        line_len(n);
        check("R11 new line length", n, 12);
        wr(REG_HORZ, CFG_HORZ);
        wait_pos(0, 0);
        line_len(n);
        check("R11 restored line", n, 10);
    endtask

    task automatic t_interlace;
        int n;
        wr(REG_VERT, 32'h0011_0001);
        wr(REG_CHAN, CFG_CHAN | 32'h0100_0000);
        while (!(field_o && h_pos_o == '0 && v_pos_o == '0)) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end
        while (!(!field_o && h_pos_o == '0 && v_pos_o == '0));
        check("R6 field 1 length", n, 90);
        n = 0;
        do begin @(negedge clk); n++; end
        while (!(field_o && h_pos_o == '0 && v_pos_o == '0));
        check("R6 field 0 length", n, 80);
        wr(REG_VERT, CFG_VERT);
        wr(REG_CHAN, CFG_CHAN);
        repeat (200) @(negedge clk);
        check("R6 progressive field", {31'b0, field_o}, 32'h0);
    endtask

    task automatic t_divider;
        int n;
        wr(REG_CHAN, CFG_CHAN | 32'h1);
        line_len(n);
        check("R12 divide by 2", n, 20);
        pix_ce = 1'b0;
        repeat (7) @(negedge clk);
        line_len(n);
        check("R12 divider restarts", n, 20);
        wr(REG_CHAN, CFG_CHAN);
        line_len(n);
        check("R12 no divide", n, 10);
    endtask

    // pix_ce gated low: pixels advance only on enabled clocks
    always @(negedge clk) if (!pix_ce && !rst) pix_ce <= 1'b1;

    task automatic t_disable;
        wr(REG_GLOBAL, 32'h0);
        @(negedge clk);
        check("R2 disabled origin", {h_pos_o, v_pos_o}, 24'h0);
        check("R2 disabled outputs", {29'b0, hsync_o, vsync_o, de_o}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst    = 1'b1;
        pix_ce = 1'b1;
        wr_en  = 1'b0;
        addr   = '0;
        wdata  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tristate();
        t_enables();
        t_geometry();
        t_start();
        t_irq();
        t_polarity();
        t_shadow();
        t_interlace();
        t_divider();
        t_disable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule